// File: doc/BRIEF.md
# SPI Controller FIFO Pair and Status Word

This block holds the transmit and receive frame FIFOs of a SPI master controller, along with the register-side logic around them. Software reaches it through a small word-addressed register port. One data address pushes into the transmit FIFO on a write and pops the receive FIFO on a read. Separate addresses return the fill level of each FIFO, a transmit threshold and a 7-bit status word. The threshold only accepts values below the FIFO depth, so software can find the depth by writing values and reading them back.

The serial shift engine sits outside the block. It takes transmit frames through a valid/pop pair. It returns received frames through a push strobe. It also reports when it is idle and when it sees a bus collision. Clearing the enable bit empties both FIFOs at once, so nothing stale survives into the next transfer. Software treats a transfer as complete when the status word shows transmit-empty set and busy clear.

Register addresses on `reg_addr_i`:
- 0: enable, bit 0.
- 1: transmit threshold.
- 2: transmit level.
- 3: receive level.
- 4: status.
- 5: data.
- 6: error clear. It reads as 0.
- 7: reserved. It reads as 0.

Top module: `spi_fifo_pair`

## Requirements
- R1: The status word at address 4 carries these bits. Bit 0 is busy. Bit 1 is transmit FIFO not full. Bit 2 is transmit FIFO empty. Bit 3 is receive FIFO not empty. Bit 4 is receive FIFO full. Bit 5 is transmit error. Bit 6 is collision. Bits 31..7 read 0.
- R2: A write to address 5 while enabled and not full appends the low DW bits to the transmit FIFO. The engine sees frames in write order on `eng_tx_data_o` whenever `eng_tx_valid_o` is 1. An `eng_tx_pop_i` while the FIFO is empty is ignored.
- R3: A data write while the transmit FIFO is full is dropped and sets the transmit-error bit. A read of address 6 clears the transmit-error and collision bits. A set in the same cycle wins over the clear.
- R4: A read of address 5 returns the oldest receive frame, zero-extended, and removes it. When the receive FIFO is empty the read returns 0 and the levels do not change.
- R5: Addresses 2 and 3 return the current entry counts of the transmit and receive FIFOs, from 0 to DEPTH.
- R6: A write to address 1 with a value below DEPTH is stored and read back. A value at or above DEPTH is not stored, and the previous value stays.
- R7: Address 0 bit 0 is the enable. Writing 0 empties both FIFOs and clears busy by the next cycle. While the enable is 0, data writes and engine pushes are ignored.
- R8: Busy goes to 1 in the cycle after an accepted transmit pop. It goes to 0 after a cycle in which `eng_idle_i` is 1 and no pop is accepted.
- R9: `eng_coll_i` sets the collision bit in the next cycle.
- R10: An engine push while the receive FIFO is full is dropped, even if the FIFO is read in the same cycle.
- R11: `tx_thr_o` is 1 whenever the transmit level is at or below the stored threshold.
- R12: After reset the enable is 0, the threshold is 0 and both levels are 0. The status word reads 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| eng_tx_valid_o | output | 1 | Transmit FIFO holds a frame |
| eng_tx_data_o | output | DW | Oldest transmit frame |
| eng_tx_pop_i | input | 1 | Engine takes the oldest transmit frame |
| eng_rx_push_i | input | 1 | Engine delivers a received frame |
| eng_rx_data_i | input | DW | Received frame |
| eng_idle_i | input | 1 | Engine has no frame in flight |
| eng_coll_i | input | 1 | Engine saw a bus collision |
| tx_thr_o | output | 1 | Transmit level at or below the threshold |

## Verification
A miscounted level or a misplaced pointer shows up at the ports within one clock. It appears as a wrong level readback, a wrong status bit, or a frame on `eng_tx_data_o` that differs from the one a queue model predicts. A flag that sticks or fails to set is visible on the status read in the cycle after the event. This applies to busy, transmit error and collision. A flush that misses one FIFO leaves a non-zero level readable in the first cycle after the disable.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  typedef enum logic [2:0] {
    RA_ENABLE  = 3'd0,
    RA_TX_THR  = 3'd1,
    RA_TX_LVL  = 3'd2,
    RA_RX_LVL  = 3'd3,
    RA_STATUS  = 3'd4,
    RA_DATA    = 3'd5,
    RA_ERR_CLR = 3'd6
  } reg_addr_e;

  localparam int unsigned ST_BUSY    = 0;
  localparam int unsigned ST_TX_NF   = 1;
  localparam int unsigned ST_TX_EMPT = 2;
  localparam int unsigned ST_RX_NE   = 3;
  localparam int unsigned ST_RX_FULL = 4;
  localparam int unsigned ST_TX_ERR  = 5;
  localparam int unsigned ST_COLL    = 6;
  localparam int unsigned ST_W       = 7;
endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] level_q;
  logic          push_ok, pop_ok;

  assign full_o  = (level_q == LW'(DEPTH));
  assign empty_o = (level_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= inc_ptr(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign level_o = level_q;

  a_r5_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= LW'(DEPTH));
  a_r7_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  a_r3_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(level_q));
endmodule

// File: rtl/sfp_status.sv
module sfp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic tx_pop_i,
  input  logic eng_idle_i,
  input  logic tx_err_set_i,
  input  logic coll_set_i,
  input  logic err_clr_i,
  output logic busy_o,
  output logic tx_err_o,
  output logic coll_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      tx_err_o <= 1'b0;
      coll_o   <= 1'b0;
    end else begin
      if (flush_i)         busy_o <= 1'b0;
      else if (tx_pop_i)   busy_o <= 1'b1;
      else if (eng_idle_i) busy_o <= 1'b0;
      // set beats clear
      if (tx_err_set_i)   tx_err_o <= 1'b1;
      else if (err_clr_i) tx_err_o <= 1'b0;
      if (coll_set_i)     coll_o <= 1'b1;
      else if (err_clr_i) coll_o <= 1'b0;
    end
  end

  a_r8_busy_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_pop_i && !flush_i) |=> busy_o);
  a_r8_busy_drops_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_idle_i && !tx_pop_i) |=> !busy_o);
  a_r3_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_err_set_i |=> tx_err_o);
  a_r9_coll_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_set_i |=> coll_o);
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 16,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_sel_i,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          eng_tx_valid_o,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_tx_pop_i,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          eng_idle_i,
  input  logic          eng_coll_i,
  output logic          tx_thr_o
);
  logic          en_q;
  logic [LW-1:0] thr_q;
  logic          wr, rd, dis_wr, flush;
  logic          data_wr, tx_push, tx_pop, tx_err_set;
  logic          rx_push, rx_pop, err_clr;
  logic [DW-1:0] tx_rdata, rx_rdata;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          busy, tx_err, coll;
  logic [ST_W-1:0] status;
  reg_addr_e     addr;

  assign addr       = reg_addr_e'(reg_addr_i);
  assign wr         = reg_sel_i && reg_we_i;
  assign rd         = reg_sel_i && !reg_we_i;
  assign dis_wr     = wr && (addr == RA_ENABLE) && !reg_wdata_i[0];
  assign flush      = !en_q || dis_wr;
  assign data_wr    = wr && (addr == RA_DATA) && en_q;
  assign tx_push    = data_wr && !tx_full;
  assign tx_err_set = data_wr && tx_full;
  assign tx_pop     = eng_tx_pop_i && !tx_empty;
  assign rx_push    = eng_rx_push_i && en_q && !rx_full;
  assign rx_pop     = rd && (addr == RA_DATA) && !rx_empty;
  assign err_clr    = rd && (addr == RA_ERR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else if (wr) begin
      if (addr == RA_ENABLE) en_q <= reg_wdata_i[0];
      // out-of-range values are not stored: lets software size the FIFO
      if (addr == RA_TX_THR && reg_wdata_i < 32'(DEPTH)) thr_q <= reg_wdata_i[LW-1:0];
    end
  end

  sfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push), .wdata_i(reg_wdata_i[DW-1:0]), .pop_i(tx_pop),
    .rdata_o(tx_rdata), .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty)
  );

  sfp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push), .wdata_i(eng_rx_data_i), .pop_i(rx_pop),
    .rdata_o(rx_rdata), .level_o(rx_level), .full_o(rx_full), .empty_o(rx_empty)
  );

  sfp_status u_status (
    .clk_i, .rst_ni, .flush_i(flush), .tx_pop_i(tx_pop), .eng_idle_i,
    .tx_err_set_i(tx_err_set), .coll_set_i(eng_coll_i), .err_clr_i(err_clr),
    .busy_o(busy), .tx_err_o(tx_err), .coll_o(coll)
  );

  always_comb begin
    status             = '0;
    status[ST_BUSY]    = busy;
    status[ST_TX_NF]   = !tx_full;
    status[ST_TX_EMPT] = tx_empty;
    status[ST_RX_NE]   = !rx_empty;
    status[ST_RX_FULL] = rx_full;
    status[ST_TX_ERR]  = tx_err;
    status[ST_COLL]    = coll;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      RA_ENABLE: reg_rdata_o = {31'd0, en_q};
      RA_TX_THR: reg_rdata_o = 32'(thr_q);
      RA_TX_LVL: reg_rdata_o = 32'(tx_level);
      RA_RX_LVL: reg_rdata_o = 32'(rx_level);
      RA_STATUS: reg_rdata_o = 32'(status);
      RA_DATA:   reg_rdata_o = rx_empty ? 32'd0 : 32'(rx_rdata);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign eng_tx_valid_o = !tx_empty;
  assign eng_tx_data_o  = tx_rdata;
  assign tx_thr_o       = (tx_level <= thr_q);

  a_r6_thr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_q < LW'(DEPTH));
  a_r7_disabled_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (tx_level == '0 && rx_level == '0));
  a_r4_empty_read_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr == RA_DATA && rx_empty && !eng_rx_push_i) |=> $stable(rx_level));
  a_r10_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rx_push_i && rx_full && !flush) |=> (rx_level <= $past(rx_level)));
endmodule

// File: tb/tb_spi_fifo_pair.sv
module tb_spi_fifo_pair;
  localparam int D  = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          reg_sel, reg_we, tx_pop, rx_push, idle, coll;
  logic [2:0]    reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;
  logic [DW-1:0] rx_data, tx_data;
  logic          tx_valid, tx_thr;

  spi_fifo_pair #(.DEPTH(D), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_sel_i(reg_sel), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_pop_i(tx_pop),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data),
    .eng_idle_i(idle), .eng_coll_i(coll), .tx_thr_o(tx_thr)
  );

  // staged stimulus, applied at the falling edge
  bit s_sel, s_we, s_pop, s_push, s_idle, s_coll;
  int s_addr, s_wdata, s_rxd;

  // reference model
  int  txq[$], rxq[$];
  bit  m_en, m_busy, m_err, m_coll;
  int  m_thr;
  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_status();
    return (m_busy ? 1 : 0) | ((txq.size() < D) ? 2 : 0) | ((txq.size() == 0) ? 4 : 0)
         | ((rxq.size() > 0) ? 8 : 0) | ((rxq.size() == D) ? 16 : 0)
         | (m_err ? 32 : 0) | (m_coll ? 64 : 0);
  endfunction

  function automatic int exp_rdata(int a);
    case (a)
      0: return m_en ? 1 : 0;
      1: return m_thr;
      2: return txq.size();
      3: return rxq.size();
      4: return exp_status();
      5: return (rxq.size() > 0) ? rxq[0] : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0: return "R7 enable readback";
      1: return "R6 threshold readback";
      2, 3: return "R5 level";
      4: return "R1 R3 R8 R9 R10 R12 status";
      5: return "R4 data read";
      default: return "R3 clear reads zero";
    endcase
  endfunction

  task automatic tick();
    int ntx, nrx;
    bit wr, rd, dis, fl, dwr, txp, rxp, rxu;
    @(negedge clk);
    reg_sel = s_sel; reg_we = s_we; reg_addr = 3'(s_addr); reg_wdata = s_wdata;
    tx_pop = s_pop; rx_push = s_push; rx_data = DW'(s_rxd); idle = s_idle; coll = s_coll;
    #1;
    chk(rd_tag(s_addr), reg_rdata, exp_rdata(s_addr));
    chk("R2 tx valid", int'(tx_valid), (txq.size() > 0) ? 1 : 0);
    if (txq.size() > 0) chk("R2 tx frame order", int'(tx_data), txq[0]);
    chk("R11 threshold flag", int'(tx_thr), (txq.size() <= m_thr) ? 1 : 0);
    @(posedge clk);
    ntx = txq.size(); nrx = rxq.size();
    wr  = s_sel && s_we; rd = s_sel && !s_we;
    dis = wr && s_addr == 0 && !s_wdata[0];
    fl  = !m_en || dis;
    dwr = wr && s_addr == 5 && m_en;
    txp = s_pop && ntx > 0;
    rxp = rd && s_addr == 5 && nrx > 0;
    rxu = s_push && m_en && nrx < D;
    if (dwr && ntx == D) m_err = 1; else if (rd && s_addr == 6) m_err = 0;
    if (s_coll) m_coll = 1; else if (rd && s_addr == 6) m_coll = 0;
    if (fl) m_busy = 0; else if (txp) m_busy = 1; else if (s_idle) m_busy = 0;
    if (fl) begin
      txq.delete(); rxq.delete();
    end else begin
      if (txp) void'(txq.pop_front());
      if (dwr && ntx < D) txq.push_back(s_wdata & 16'hffff);
      if (rxp) void'(rxq.pop_front());
      if (rxu) rxq.push_back(s_rxd & 16'hffff);
    end
    if (wr && s_addr == 1 && s_wdata >= 0 && s_wdata < D) m_thr = s_wdata;
    if (wr && s_addr == 0) m_en = s_wdata[0];
  endtask

  task automatic clr_stage();
    s_sel = 0; s_we = 0; s_addr = 7; s_wdata = 0;
    s_pop = 0; s_push = 0; s_rxd = 0; s_idle = 1; s_coll = 0;
  endtask

  task automatic reg_wr(int a, int v);
    clr_stage(); s_sel = 1; s_we = 1; s_addr = a; s_wdata = v; tick();
  endtask

  task automatic reg_rd(int a);
    clr_stage(); s_sel = 1; s_addr = a; tick();
  endtask

  initial begin
    reg_sel = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    tx_pop = 0; rx_push = 0; rx_data = 0; idle = 1; coll = 0;
    m_en = 0; m_busy = 0; m_err = 0; m_coll = 0; m_thr = 0;
    clr_stage();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R12: reset state
    reg_rd(4); reg_rd(0); reg_rd(1); reg_rd(2); reg_rd(3);
    // R7: data write while disabled is ignored
    reg_wr(5, 16'h1111); reg_rd(2);
    reg_wr(0, 1);
    // R6: threshold range and depth discovery
    reg_wr(1, 3); reg_rd(1);
    reg_wr(1, D); reg_rd(1);
    reg_wr(1, 255); reg_rd(1);
    reg_wr(1, D - 1); reg_rd(1);
    reg_wr(1, 2);
    // R2 R3: fill, overflow, clear
    for (int i = 0; i < D + 1; i++) begin reg_wr(5, 16'ha000 + i); reg_rd(2); end
    reg_rd(4); reg_rd(6); reg_rd(4);
    // R8: busy from pop until idle
    for (int i = 0; i < 3; i++) begin clr_stage(); s_pop = 1; s_idle = 0; s_addr = 4; tick(); end
    clr_stage(); s_idle = 0; s_addr = 4; tick();
    clr_stage(); s_addr = 4; tick();
    reg_rd(4);
    // R10 R4: receive fill past full, then drain past empty
    for (int i = 0; i < D + 2; i++) begin
      clr_stage(); s_push = 1; s_rxd = 16'h5000 + i; s_addr = 3; tick();
    end
    clr_stage(); s_sel = 1; s_addr = 5; s_push = 1; s_rxd = 16'hdead; tick();
    for (int i = 0; i < D + 1; i++) reg_rd(5);
    reg_rd(3); reg_rd(5); reg_rd(3);
    // R9: collision, set beats clear
    clr_stage(); s_coll = 1; s_addr = 4; tick();
    reg_rd(4);
    clr_stage(); s_sel = 1; s_addr = 6; s_coll = 1; tick();
    reg_rd(4); reg_rd(6); reg_rd(4);
    // R7: disable with data in both FIFOs
    reg_wr(5, 16'h0bad); reg_wr(5, 16'h0bee);
    clr_stage(); s_push = 1; s_rxd = 16'h0777; s_pop = 1; s_idle = 0; tick();
    reg_rd(4);
    reg_wr(0, 0); reg_rd(2); reg_rd(3); reg_rd(4);
    clr_stage(); s_push = 1; s_rxd = 16'h1234; s_addr = 3; tick();
    reg_wr(0, 1); reg_rd(3);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      clr_stage();
      s_sel   = ($urandom_range(0, 2) != 0);
      s_we    = $urandom_range(0, 1);
      s_addr  = $urandom_range(0, 7);
      if (s_we && s_addr == 0) s_wdata = ($urandom_range(0, 40) == 0) ? 0 : 1;
      else if (s_addr == 1)   s_wdata = $urandom_range(0, 2 * D);
      else                    s_wdata = $urandom;
      s_pop   = $urandom_range(0, 1);
      s_push  = $urandom_range(0, 1);
      s_rxd   = $urandom;
      s_idle  = $urandom_range(0, 1);
      s_coll  = ($urandom_range(0, 30) == 0);
      tick();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule